// File: doc/BRIEF.md
# Watchdog Timer with Two-Write Unlock Clear

This block supervises software by counting clock cycles once it is armed. Software arms it by writing its control register once. From then on the count runs without pause. Software keeps the system alive by writing a two-value key to a clear register before the selected period runs out. If the period expires first, the block raises a request for an initialization-level reset.

The request is a plain level. It is held until the reset controller acknowledges that it has produced either an initialization reset or an operation reset. When the initialization reset is the one that answered the request, a sticky cause bit is set in a readable reset-source word. Reading that word clears the bit.

The controls are plain strobes with data, one per register. None of them has back-pressure: a strobe is taken in the cycle in which it is high. The time-out period is a power of two. `BASE_LOG2` sets its smallest exponent, and each step of the period code adds two to the exponent. The block counts ticks of `clk`. The asynchronous `rst_n` input is the only way to disarm it.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_n` is released, `active` is 0, `init_req` is 0 and `rsrc_rdata` is all zero. Clear-register writes made while inactive change none of these.
- R2: The first `ctrl_wr` pulse sets `active` at that clock edge. Once set, `active` stays 1 until `rst_n` is asserted, and asserting `rst_n` returns it to 0. `init_req` is never 1 while `active` is 0.
- R3: `ctrl_wdata[9:8]` gives the period code k, latched on every `ctrl_wr`. With no clear and no acknowledge, `init_req` rises exactly 2^(BASE_LOG2+2k) clock edges after the edge that activated the block, or after the last clear or acknowledge edge. A period change does not reset the count. If the count already meets a shorter new period, the time-out happens on the next edge.
- R4: A clear-register write of 0x5A that directly follows a clear-register write of 0xA5 restarts the count from zero at its edge. The next time-out then comes one full period after that edge.
- R5: A clear-register write of 0xA5 always arms the key. Any other value written after 0xA5 disarms it and does not clear the count. A 0x5A written while the key is not armed has no effect.
- R6: Once `init_req` is 1, it stays 1 until a cycle in which `init_ack` or `rst_ack` is high. It is 0 after that edge. Every acknowledge edge restarts the count from zero.
- R7: Bit 13 of `rsrc_rdata` (the watchdog-cause bit) becomes 1 at an edge where `init_ack` is high while `init_req` is 1. Acknowledging with `rst_ack` does not set it. All other bits of `rsrc_rdata` read 0.
- R8: A `rsrc_rd` pulse clears the cause bit at its edge. If a set and a read occur at the same edge, the set wins.
- R9: While `init_req` is 1, the count stays stopped. Key writes and control writes do not release the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the tick source of the period |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to disarm |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_wdata | input | 16 | Control write data; bits 9:8 hold the period code |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_wdata | input | 8 | Clear write data (key bytes 0xA5, 0x5A) |
| rsrc_rd | input | 1 | Read strobe of the reset-source word; clears the cause bit |
| rsrc_rdata | output | 16 | Reset-source word; bit 13 is the watchdog cause |
| init_ack | input | 1 | Reset controller has generated an initialization reset |
| rst_ack | input | 1 | Reset controller has generated an operation reset |
| init_req | output | 1 | Initialization-reset request, held until acknowledged |
| active | output | 1 | Watchdog armed and counting |

## Verification
The hardest cases to reach from the ports are the ones where a time-out falls at an exact cycle after a broken or repeated key sequence. In these cases the only visible sign of whether the count restarted is how many edges later `init_req` rises. The stimulus first acknowledges a request, which puts the count at a known zero. It then places the key writes at known offsets and measures the rise edge against that origin. The same idea covers two other cases: shortening the period after the count has already passed the new limit, and a read and a set of the cause bit landing on the same edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_W      = 16;
  localparam int KEY_W       = 8;
  localparam int RSRC_W      = 16;
  localparam int PER_LSB     = 8;
  localparam int PER_W       = 2;
  localparam int CAUSE_BIT   = 13;
  localparam int EXP_STEP    = 2;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h5A;

  typedef enum logic {KEY_WAIT, KEY_ARMED} key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic [KEY_W-1:0] clr_wdata,
  output logic             key_done
);
  key_state_e state_q;

  assign key_done = clr_wr && (state_q == KEY_ARMED) && (clr_wdata == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KEY_WAIT;
    end else if (clr_wr) begin
      state_q <= (clr_wdata == KEY_FIRST) ? KEY_ARMED : KEY_WAIT;
    end
  end

  assert_key_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_wdata != KEY_FIRST) |=> (state_q == KEY_WAIT));
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             restart,
  input  logic [PER_W-1:0] per_sel,
  output logic             expire
);
  localparam int MAX_EXP = BASE_LOG2 + EXP_STEP * ((1 << PER_W) - 1);
  localparam int CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(1) << (BASE_LOG2 + EXP_STEP * int'(per_sel));
  end

  assign expire = run && !hold && !restart && (cnt_q >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || hold || restart || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  assert_hold_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_req_flag.sv
module wdt_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic init_ack,
  input  logic rst_ack,
  input  logic rd_clr,
  output logic req,
  output logic cause
);
  logic ack;
  assign ack = init_ack || rst_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else if (ack) begin
      req <= 1'b0;
    end else if (expire) begin
      req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= 1'b0;
    end else if (req && init_ack) begin
      cause <= 1'b1;
    end else if (rd_clr) begin
      cause <= 1'b0;
    end
  end

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  assert_req_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !req);
  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && init_ack) |=> cause);
  assert_cause_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(req && init_ack)) |=> !cause);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              clr_wr,
  input  logic [KEY_W-1:0]  clr_wdata,
  input  logic              rsrc_rd,
  output logic [RSRC_W-1:0] rsrc_rdata,
  input  logic              init_ack,
  input  logic              rst_ack,
  output logic              init_req,
  output logic              active
);
  logic [PER_W-1:0] per_q;
  logic             key_done;
  logic             expire;
  logic             cause;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:PER_LSB+PER_W], ctrl_wdata[PER_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      per_q  <= '0;
    end else if (ctrl_wr) begin
      active <= 1'b1;
      per_q  <= ctrl_wdata[PER_LSB +: PER_W];
    end
  end

  wdt_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (clr_wr),
    .clr_wdata(clr_wdata),
    .key_done (key_done)
  );

  wdt_timeout #(.BASE_LOG2(BASE_LOG2)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .hold   (init_req),
    .restart(key_done || init_ack || rst_ack),
    .per_sel(per_q),
    .expire (expire)
  );

  wdt_req_flag u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .init_ack(init_ack),
    .rst_ack (rst_ack),
    .rd_clr  (rsrc_rd),
    .req     (init_req),
    .cause   (cause)
  );

  always_comb begin
    rsrc_rdata = '0;
    rsrc_rdata[CAUSE_BIT] = cause;
  end

  assert_active_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);
  assert_no_req_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !init_req);
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  localparam int BASE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        clr_wr = 1'b0;
  logic [7:0]  clr_wdata = '0;
  logic        rsrc_rd = 1'b0;
  logic [15:0] rsrc_rdata;
  logic        init_ack = 1'b0;
  logic        rst_ack = 1'b0;
  logic        init_req;
  logic        active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R1";

  // reference model state
  int m_active = 0, m_per = 0, m_cnt = 0, m_req = 0, m_armed = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  wdt_keyed #(.BASE_LOG2(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .rsrc_rd(rsrc_rd),
    .rsrc_rdata(rsrc_rdata), .init_ack(init_ack), .rst_ack(rst_ack),
    .init_req(init_req), .active(active)
  );

  function automatic int lim(int code);
    return 1 << (BASE + 2 * code);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
               tag, act, act, exp, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int n_active, n_per, n_cnt, n_req, n_armed, n_flag;
    bit ack, clr_ok;
    cyc++;
    if (!rst_n) begin
      n_active = 0; n_per = 0; n_cnt = 0; n_req = 0; n_armed = 0; n_flag = 0;
    end else begin
      ack    = init_ack || rst_ack;
      clr_ok = clr_wr && clr_wdata == 8'h5A && m_armed != 0;
      n_armed = clr_wr ? int'(clr_wdata == 8'hA5) : m_armed;
      n_flag  = (m_req != 0 && init_ack) ? 1 : (rsrc_rd ? 0 : m_flag);
      n_active = (m_active != 0 || ctrl_wr) ? 1 : 0;
      n_per    = ctrl_wr ? int'(ctrl_wdata[9:8]) : m_per;
      n_req = m_req; n_cnt = m_cnt;
      if (ack) begin n_req = 0; n_cnt = 0; end
      else if (m_req != 0 || m_active == 0 || clr_ok) n_cnt = 0;
      else if (m_cnt >= lim(m_per) - 1) begin n_req = 1; n_cnt = 0; end
      else n_cnt = m_cnt + 1;
    end
    m_active = n_active; m_per = n_per; m_cnt = n_cnt;
    m_req = n_req; m_armed = n_armed; m_flag = n_flag;
    #1;
    chk(active == m_active[0], {phase, " active vs model"}, int'(active), m_active);
    chk(init_req == m_req[0], {phase, " init_req vs model"}, int'(init_req), m_req);
    chk(rsrc_rdata == (m_flag != 0 ? 16'h2000 : 16'h0000), {phase, " rsrc_rdata vs model"},
        int'(rsrc_rdata), m_flag != 0 ? 32'h2000 : 0);
  end

  task automatic wr_ctrl(input logic [15:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_clr(input logic [7:0] d);
    @(negedge clk); clr_wr = 1'b1; clr_wdata = d;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) rst_ack = 1'b1;
    else if (which == 1) init_ack = 1'b1;
    else if (which == 2) rsrc_rd = 1'b1;
    else begin init_ack = 1'b1; rsrc_rd = 1'b1; end
    @(negedge clk);
    rst_ack = 1'b0; init_ack = 1'b0; rsrc_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles from origin (a cyc value) until init_req seen high
  task automatic time_to_req(input int origin, output int n);
    while (!init_req && cyc - origin < 4000) begin
      @(posedge clk); #1;
    end
    n = cyc - origin;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual %0d expected 0 cycles left", 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, c0;
    idle(4);
    rst_n = 1'b1;
    // R1: reset state, key writes while inactive do nothing
    phase = "R1";
    idle(10);
    chk(active == 1'b0, "R1 active after reset", int'(active), 0);
    chk(init_req == 1'b0, "R1 init_req after reset", int'(init_req), 0);
    chk(rsrc_rdata == 16'h0, "R1 rsrc_rdata after reset", int'(rsrc_rdata), 0);
    wr_clr(8'hA5); wr_clr(8'h5A); idle(20);
    chk(init_req == 1'b0 && active == 1'b0, "R1 clear while inactive", int'(init_req), 0);

    // R2/R3: activation with code 0
    phase = "R3";
    wr_ctrl(16'h0000);
    c0 = cyc;
    chk(active == 1'b1, "R2 active after first write", int'(active), 1);
    time_to_req(c0, n);
    chk(n == lim(0), "R3 code 0 period", n, lim(0));

    // R9: request holds, key and control writes do not release it
    phase = "R9";
    idle(6);
    wr_clr(8'hA5); wr_clr(8'h5A);
    wr_ctrl(16'h0100);
    chk(init_req == 1'b1, "R9 request held through writes", int'(init_req), 1);

    // R6/R7: operation reset acknowledge
    phase = "R6";
    pulse(0);
    c0 = cyc;
    chk(init_req == 1'b0, "R6 request released by rst_ack", int'(init_req), 0);
    chk(rsrc_rdata == 16'h0, "R7 rst_ack leaves cause clear", int'(rsrc_rdata), 0);
    time_to_req(c0, n);
    chk(n == lim(1), "R6 count restarts at ack, code 1", n, lim(1));

    // R7: initialization acknowledge sets cause
    phase = "R7";
    pulse(1);
    chk(rsrc_rdata == 16'h2000, "R7 cause bit set", int'(rsrc_rdata), 32'h2000);
    chk(init_req == 1'b0, "R6 request released by init_ack", int'(init_req), 0);

    // R8: read clears; set wins over read
    phase = "R8";
    pulse(2);
    chk(rsrc_rdata == 16'h0, "R8 read clears cause", int'(rsrc_rdata), 0);
    time_to_req(cyc, n);
    pulse(3);
    chk(rsrc_rdata == 16'h2000, "R8 set wins over read", int'(rsrc_rdata), 32'h2000);
    pulse(2);
    chk(rsrc_rdata == 16'h0, "R8 read clears again", int'(rsrc_rdata), 0);

    // R4: periodic keyed clears keep it quiet
    phase = "R4";
    for (int i = 0; i < 10; i++) begin
      idle(10);
      wr_clr(8'hA5); wr_clr(8'h5A);
    end
    chk(init_req == 1'b0, "R4 no time-out with regular clears", int'(init_req), 0);
    c0 = cyc;
    time_to_req(c0, n);
    chk(n == lim(1), "R4 full period after clear", n, lim(1));

    // R5: broken sequence does not clear
    phase = "R5";
    pulse(0); c0 = cyc;
    idle(15); wr_clr(8'hA5); wr_clr(8'h33); wr_clr(8'h5A);
    time_to_req(c0, n);
    chk(n == lim(1), "R5 A5,33,5A does not clear", n, lim(1));
    pulse(0); c0 = cyc;
    idle(15); wr_clr(8'h5A);
    time_to_req(c0, n);
    chk(n == lim(1), "R5 lone 5A does not clear", n, lim(1));
    pulse(0);
    idle(15); wr_clr(8'hA5); wr_clr(8'hA5); wr_clr(8'h5A);
    c0 = cyc;
    time_to_req(c0, n);
    chk(n == lim(1), "R5 A5,A5,5A clears", n, lim(1));

    // R3: longer codes and shortening
    phase = "R3";
    pulse(0); c0 = cyc;
    wr_ctrl(16'h0200);
    time_to_req(c0, n);
    chk(n == lim(2), "R3 code 2 period", n, lim(2));
    pulse(0); c0 = cyc;
    wr_ctrl(16'hFF00 | 16'h0300);
    time_to_req(c0, n);
    chk(n == lim(3), "R3 code 3 period, other bits ignored", n, lim(3));
    pulse(0);
    idle(100);
    wr_ctrl(16'h0000);
    c0 = cyc;
    time_to_req(c0, n);
    chk(n == 1, "R3 shorter period expires next edge", n, 1);

    // R2: only reset disarms
    phase = "R2";
    idle(3);
    rst_n = 1'b0;
    idle(3);
    chk(active == 1'b0 && init_req == 1'b0, "R2 reset disarms", int'(active), 0);
    rst_n = 1'b1;
    idle(40);
    chk(active == 1'b0 && init_req == 1'b0, "R2 stays inactive after reset", int'(init_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule